// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block resolves read-after-write hazards in a five-stage load/store pipeline (fetch, decode, execute, memory, writeback) by steering results that are still in flight to the instructions that need them. It reads the instruction words held in the decode, execute and memory stages, together with the destination register numbers of the memory and writeback stages. From these it computes a select code for each of four three-input operand multiplexers, and it contains the multiplexers themselves.

Two of the multiplexers feed the ALU inputs in the execute stage. They can take the memory-stage result or the writeback result. The other two feed the equality comparator in decode, which resolves branches early. These two can only take the memory-stage result. A result from the memory stage is never forwarded while the instruction there is a load, because its data is not ready yet. Stalling on that case is handled by a separate hazard unit. The unit is purely combinational.

Top module: `fwd_unit`

## Requirements
- R1: When the execute instruction's first source field (bits 25:21) equals a nonzero memory-stage destination and the memory-stage opcode is not a load, `ex_sel_a` is 2'b01 and `ex_alu_a` equals `mem_value`.
- R2: When R1's memory condition does not hold for operand A, and the first source field equals a nonzero writeback destination, `ex_sel_a` is 2'b10 and `ex_alu_a` equals `wb_value`.
- R3: Execute operand B follows the R1/R2 rules using the second source field (bits 20:16). A register number that appears only in bits 20:16 has no effect on operand A.
- R4: When no forwarding rule matches, every select is 2'b00 and each output passes its register value (`ex_reg_a`, `ex_reg_b`, `id_reg_a`, `id_reg_b`).
- R5: The decode comparator inputs use the R1 memory-stage rule on bits 25:21 (`id_sel_a`) and bits 20:16 (`id_sel_b`). A writeback match is ignored for them: they never select 2'b10.
- R6: A memory-stage opcode (bits 31:26) equal to 6'b100011 (load) blocks every memory-stage forward. An execute operand may still take the writeback value.
- R7: A destination number of zero never causes forwarding, even when it matches a source field of zero.
- R8: When both the memory-stage rule and the writeback rule match an execute operand, the memory-stage value is selected (2'b01).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| id_ir | input | 32 | Instruction word in the decode stage |
| ex_ir | input | 32 | Instruction word in the execute stage |
| mem_ir | input | 32 | Instruction word in the memory stage (opcode used) |
| mem_rd | input | 5 | Destination register number of the memory stage (0 if none) |
| wb_rd | input | 5 | Destination register number of the writeback stage (0 if none) |
| id_reg_a | input | 32 | Register-file read value for decode source 1 |
| id_reg_b | input | 32 | Register-file read value for decode source 2 |
| ex_reg_a | input | 32 | Operand A value carried into execute |
| ex_reg_b | input | 32 | Operand B value carried into execute |
| mem_value | input | 32 | ALU result held in the memory stage |
| wb_value | input | 32 | Result being written back |
| ex_sel_a | output | 2 | Select code for ALU operand A |
| ex_sel_b | output | 2 | Select code for ALU operand B |
| id_sel_a | output | 2 | Select code for comparator input A |
| id_sel_b | output | 2 | Select code for comparator input B |
| ex_alu_a | output | 32 | Forwarded ALU operand A |
| ex_alu_b | output | 32 | Forwarded ALU operand B |
| id_cmp_a | output | 32 | Forwarded comparator input A |
| id_cmp_b | output | 32 | Forwarded comparator input B |

## Verification
The hardest case to reach is one where every condition is live at once. A load sits in the memory stage, and its destination matches an execute source that the writeback stage also targets. The unit must then skip the memory value and fall back to writeback. Uniform 5-bit register numbers almost never line up like this. The random stimulus therefore draws register numbers from a small pool that includes zero, and makes the memory opcode a load about a third of the time. Directed cases pin down the exact priority, load-block and zero-register situations.

// File: rtl/fwd_pkg.sv
// fwd_pkg: shared select encoding and lane indices for the forwarding unit.
// Assumes select codes are consumed by three-input operand multiplexers.
package fwd_pkg;

    typedef enum logic [1:0] {
        FWD_REG = 2'b00,
        FWD_MEM = 2'b01,
        FWD_WB  = 2'b10
    } fwd_sel_e;

    localparam int LANES     = 4;
    localparam int LANE_EX_A = 0;
    localparam int LANE_EX_B = 1;
    localparam int LANE_ID_A = 2;
    localparam int LANE_ID_B = 3;

endpackage

// File: rtl/fwd_match_unit.sv
// fwd_match_unit: decides the forwarding source for one operand.
// The memory stage wins over writeback because its result is younger.
// Destination zero never matches. A load in the memory stage blocks the memory path.
// USE_WB=0 builds a lane with no writeback path (decode comparator lanes).
module fwd_match_unit
    import fwd_pkg::*;
#(
    parameter int REG_W  = 5,
    parameter bit USE_WB = 1'b1
) (
    input  logic [REG_W-1:0] src_reg,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_is_load,
    input  logic [REG_W-1:0] wb_rd,
    output fwd_sel_e         sel
);

    logic mem_match;
    logic wb_match;
    logic mem_hit;
    logic wb_hit;

    // Raw register-number comparisons, ignoring register zero.
    always_comb begin
        mem_match = (src_reg == mem_rd) && (mem_rd != '0);
        wb_match  = (src_reg == wb_rd) && (wb_rd != '0);
    end

    // Qualify each match with the stage's eligibility.
    always_comb begin
        mem_hit = mem_match && !mem_is_load;
        wb_hit  = USE_WB && wb_match;
    end

    // Priority encode: memory stage first, then writeback, else register value.
    always_comb begin
        if (mem_hit) begin
            sel = FWD_MEM;
        end else if (wb_hit) begin
            sel = FWD_WB;
        end else begin
            sel = FWD_REG;
        end
    end

    // Guards on the chosen source against the stage inputs.
    always_comb begin
        if (sel != FWD_REG) begin
            assert_nonzero_dest_R7: assert (src_reg != '0)
                else $error("forward selected for source register zero");
        end
        if (sel == FWD_MEM) begin
            assert_no_load_fwd_R6: assert (!mem_is_load && src_reg == mem_rd)
                else $error("memory forward while load or mismatch");
        end
        if (sel == FWD_WB) begin
            assert_wb_match_R2: assert (src_reg == wb_rd && USE_WB)
                else $error("writeback forward without match");
        end
        if (!mem_is_load && mem_rd != '0 && src_reg == mem_rd) begin
            assert_mem_priority_R8: assert (sel == FWD_MEM)
                else $error("memory-stage match not selected");
        end
    end

endmodule

// File: rtl/fwd_mux3.sv
// fwd_mux3: three-input operand multiplexer steered by a forwarding select.
// Assumes the unused select code 2'b11 never occurs and maps it to the register input.
module fwd_mux3
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fwd_sel_e          sel,
    input  logic [DATA_W-1:0] in_reg,
    input  logic [DATA_W-1:0] in_mem,
    input  logic [DATA_W-1:0] in_wb,
    output logic [DATA_W-1:0] out
);

    // Pick the operand source named by the select code.
    always_comb begin
        unique case (sel)
            FWD_MEM: out = in_mem;
            FWD_WB:  out = in_wb;
            default: out = in_reg;
        endcase
    end

    // The output must carry the value of the selected input.
    always_comb begin
        if (sel == FWD_MEM) begin
            assert_mux_mem_R1: assert (out == in_mem)
                else $error("mux output differs from memory input");
        end
        if (sel == FWD_REG) begin
            assert_mux_reg_R4: assert (out == in_reg)
                else $error("mux output differs from register input");
        end
    end

endmodule

// File: rtl/fwd_unit.sv
// fwd_unit: operand forwarding for the execute ALU inputs and decode branch comparator.
// Extracts source fields and the memory-stage opcode from instruction words.
// Builds four lanes: two execute lanes with memory and writeback paths, and two
// decode lanes with the memory path only. Purely combinational.
// Assumes destinations are already zero for instructions that write no register.
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int              DATA_W   = 32,
    parameter int              IR_W     = 32,
    parameter int              REG_W    = 5,
    parameter int              OPC_W    = 6,
    parameter int              SRC1_LSB = 21,
    parameter int              SRC2_LSB = 16,
    parameter int              OPC_LSB  = 26,
    parameter logic [OPC_W-1:0] LOAD_OPC = 6'b100011
) (
    input  logic [IR_W-1:0]   id_ir,
    input  logic [IR_W-1:0]   ex_ir,
    input  logic [IR_W-1:0]   mem_ir,
    input  logic [REG_W-1:0]  mem_rd,
    input  logic [REG_W-1:0]  wb_rd,
    input  logic [DATA_W-1:0] id_reg_a,
    input  logic [DATA_W-1:0] id_reg_b,
    input  logic [DATA_W-1:0] ex_reg_a,
    input  logic [DATA_W-1:0] ex_reg_b,
    input  logic [DATA_W-1:0] mem_value,
    input  logic [DATA_W-1:0] wb_value,
    output logic [1:0]        ex_sel_a,
    output logic [1:0]        ex_sel_b,
    output logic [1:0]        id_sel_a,
    output logic [1:0]        id_sel_b,
    output logic [DATA_W-1:0] ex_alu_a,
    output logic [DATA_W-1:0] ex_alu_b,
    output logic [DATA_W-1:0] id_cmp_a,
    output logic [DATA_W-1:0] id_cmp_b
);

    localparam int EX_LANES = 2;

    logic                mem_is_load;
    logic [REG_W-1:0]    lane_src [LANES];
    logic [DATA_W-1:0]   lane_reg [LANES];
    logic [DATA_W-1:0]   lane_out [LANES];
    fwd_sel_e            lane_sel [LANES];

    // Detect a load in the memory stage from its opcode field.
    always_comb begin
        mem_is_load = (mem_ir[OPC_LSB +: OPC_W] == LOAD_OPC);
    end

    // Route source fields and register values to their lanes.
    always_comb begin
        lane_src[LANE_EX_A] = ex_ir[SRC1_LSB +: REG_W];
        lane_src[LANE_EX_B] = ex_ir[SRC2_LSB +: REG_W];
        lane_src[LANE_ID_A] = id_ir[SRC1_LSB +: REG_W];
        lane_src[LANE_ID_B] = id_ir[SRC2_LSB +: REG_W];
        lane_reg[LANE_EX_A] = ex_reg_a;
        lane_reg[LANE_EX_B] = ex_reg_b;
        lane_reg[LANE_ID_A] = id_reg_a;
        lane_reg[LANE_ID_B] = id_reg_b;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam bit HAS_WB = (g < EX_LANES);

        fwd_match_unit #(
            .REG_W  (REG_W),
            .USE_WB (HAS_WB)
        ) u_match (
            .src_reg     (lane_src[g]),
            .mem_rd      (mem_rd),
            .mem_is_load (mem_is_load),
            .wb_rd       (wb_rd),
            .sel         (lane_sel[g])
        );

        fwd_mux3 #(
            .DATA_W (DATA_W)
        ) u_mux (
            .sel    (lane_sel[g]),
            .in_reg (lane_reg[g]),
            .in_mem (mem_value),
            .in_wb  (wb_value),
            .out    (lane_out[g])
        );
    end

    // Drive the output ports from the lane results.
    always_comb begin
        ex_sel_a = lane_sel[LANE_EX_A];
        ex_sel_b = lane_sel[LANE_EX_B];
        id_sel_a = lane_sel[LANE_ID_A];
        id_sel_b = lane_sel[LANE_ID_B];
        ex_alu_a = lane_out[LANE_EX_A];
        ex_alu_b = lane_out[LANE_EX_B];
        id_cmp_a = lane_out[LANE_ID_A];
        id_cmp_b = lane_out[LANE_ID_B];
    end

    // Decode comparator lanes must never take the writeback value.
    always_comb begin
        assert_id_no_wb_R5: assert (id_sel_a != FWD_WB && id_sel_b != FWD_WB)
            else $error("decode comparator selected writeback");
    end

endmodule

// File: tb/fwd_unit_tb.sv
// fwd_unit_tb_top: directed corner cases plus seeded random stimulus,
// checked against reference functions derived from the forwarding rules.
module fwd_unit_tb_top;

    localparam time CLK_HALF = 2ns;
    localparam int  N_RAND   = 3000;
    localparam logic [5:0] OPC_LOAD = 6'b100011;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] id_ir, ex_ir, mem_ir;
    logic [4:0]  mem_rd, wb_rd;
    logic [31:0] id_reg_a, id_reg_b, ex_reg_a, ex_reg_b, mem_value, wb_value;
    logic [1:0]  ex_sel_a, ex_sel_b, id_sel_a, id_sel_b;
    logic [31:0] ex_alu_a, ex_alu_b, id_cmp_a, id_cmp_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_HALF) clk = ~clk;

    fwd_unit dut_i (
        .id_ir(id_ir), .ex_ir(ex_ir), .mem_ir(mem_ir),
        .mem_rd(mem_rd), .wb_rd(wb_rd),
        .id_reg_a(id_reg_a), .id_reg_b(id_reg_b),
        .ex_reg_a(ex_reg_a), .ex_reg_b(ex_reg_b),
        .mem_value(mem_value), .wb_value(wb_value),
        .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b),
        .id_sel_a(id_sel_a), .id_sel_b(id_sel_b),
        .ex_alu_a(ex_alu_a), .ex_alu_b(ex_alu_b),
        .id_cmp_a(id_cmp_a), .id_cmp_b(id_cmp_b)
    );

    function automatic logic [1:0] ref_sel(logic [4:0] src, logic [4:0] mrd, logic ld,
                                           logic [4:0] wrd, bit use_wb);
        if (src == mrd && mrd != 5'd0 && !ld) return 2'b01;
        if (use_wb && src == wrd && wrd != 5'd0) return 2'b10;
        return 2'b00;
    endfunction

    function automatic logic [31:0] ref_data(logic [1:0] s, logic [31:0] r,
                                             logic [31:0] m, logic [31:0] w);
        if (s == 2'b01) return m;
        if (s == 2'b10) return w;
        return r;
    endfunction

    function automatic logic [31:0] mk_ir(logic [5:0] opc, logic [4:0] rs, logic [4:0] rt);
        return {opc, rs, rt, 16'($urandom)};
    endfunction

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic set_case(logic [4:0] exs, logic [4:0] ext, logic [4:0] ids, logic [4:0] idt,
                            logic [4:0] mrd, logic ld, logic [4:0] wrd);
        @(posedge clk);
        ex_ir     = mk_ir(6'b000000, exs, ext);
        id_ir     = mk_ir(6'b000100, ids, idt);
        mem_ir    = mk_ir(ld ? OPC_LOAD : 6'b000000, 5'($urandom), 5'($urandom));
        mem_rd    = mrd;
        wb_rd     = wrd;
        id_reg_a  = $urandom; id_reg_b = $urandom;
        ex_reg_a  = $urandom; ex_reg_b = $urandom;
        mem_value = $urandom; wb_value = $urandom;
        @(negedge clk);
    endtask

    // Full comparison of all four lanes against the reference functions.
    task automatic check_all(string req);
        logic ld;
        logic [1:0] e0, e1, e2, e3;
        ld = (mem_ir[31:26] == OPC_LOAD);
        e0 = ref_sel(ex_ir[25:21], mem_rd, ld, wb_rd, 1'b1);
        e1 = ref_sel(ex_ir[20:16], mem_rd, ld, wb_rd, 1'b1);
        e2 = ref_sel(id_ir[25:21], mem_rd, ld, wb_rd, 1'b0);
        e3 = ref_sel(id_ir[20:16], mem_rd, ld, wb_rd, 1'b0);
        chk(req, "ex_sel_a", 32'(ex_sel_a), 32'(e0));
        chk(req, "ex_sel_b", 32'(ex_sel_b), 32'(e1));
        chk(req, "id_sel_a", 32'(id_sel_a), 32'(e2));
        chk(req, "id_sel_b", 32'(id_sel_b), 32'(e3));
        chk(req, "ex_alu_a", ex_alu_a, ref_data(e0, ex_reg_a, mem_value, wb_value));
        chk(req, "ex_alu_b", ex_alu_b, ref_data(e1, ex_reg_b, mem_value, wb_value));
        chk(req, "id_cmp_a", id_cmp_a, ref_data(e2, id_reg_a, mem_value, wb_value));
        chk(req, "id_cmp_b", id_cmp_b, ref_data(e3, id_reg_b, mem_value, wb_value));
    endtask

    function automatic logic [4:0] pick_reg();
        logic [2:0] k;
        k = 3'($urandom_range(0, 7));
        return (k < 3'd5) ? 5'(k) : 5'($urandom);
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        id_ir = '0; ex_ir = '0; mem_ir = '0; mem_rd = '0; wb_rd = '0;
        id_reg_a = 32'h1111_0001; id_reg_b = 32'h1111_0002;
        ex_reg_a = 32'h2222_0001; ex_reg_b = 32'h2222_0002;
        mem_value = 32'h3333_3333; wb_value = 32'h4444_4444;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 / R7: all-zero state, register zero everywhere, nothing forwards.
        chk("R4", "ex_sel_a idle", 32'(ex_sel_a), 32'd0);
        chk("R7", "id_sel_b idle", 32'(id_sel_b), 32'd0);
        chk("R4", "ex_alu_b idle", ex_alu_b, 32'h2222_0002);

        // R1: execute A matches a non-load memory destination.
        set_case(5'd3, 5'd9, 5'd10, 5'd11, 5'd3, 1'b0, 5'd12);
        chk("R1", "ex_sel_a", 32'(ex_sel_a), 32'd1);
        chk("R1", "ex_alu_a", ex_alu_a, mem_value);

        // R2: execute A matches writeback only.
        set_case(5'd4, 5'd9, 5'd10, 5'd11, 5'd7, 1'b0, 5'd4);
        chk("R2", "ex_sel_a", 32'(ex_sel_a), 32'd2);
        chk("R2", "ex_alu_a", ex_alu_a, wb_value);

        // R3: register only in bits 20:16 forwards B and leaves A alone.
        set_case(5'd1, 5'd6, 5'd10, 5'd11, 5'd6, 1'b0, 5'd13);
        chk("R3", "ex_sel_b", 32'(ex_sel_b), 32'd1);
        chk("R3", "ex_sel_a", 32'(ex_sel_a), 32'd0);
        chk("R3", "ex_alu_a", ex_alu_a, ex_reg_a);
        set_case(5'd1, 5'd8, 5'd10, 5'd11, 5'd2, 1'b0, 5'd8);
        chk("R3", "ex_alu_b wb", ex_alu_b, wb_value);

        // R5: decode lanes take memory but ignore a writeback match.
        set_case(5'd1, 5'd2, 5'd5, 5'd6, 5'd5, 1'b0, 5'd6);
        chk("R5", "id_sel_a", 32'(id_sel_a), 32'd1);
        chk("R5", "id_cmp_a", id_cmp_a, mem_value);
        chk("R5", "id_sel_b", 32'(id_sel_b), 32'd0);
        chk("R5", "id_cmp_b", id_cmp_b, id_reg_b);

        // R6: load in memory stage blocks; execute A falls back to writeback.
        set_case(5'd7, 5'd7, 5'd7, 5'd9, 5'd7, 1'b1, 5'd7);
        chk("R6", "ex_sel_a", 32'(ex_sel_a), 32'd2);
        chk("R6", "ex_alu_b", ex_alu_b, wb_value);
        chk("R6", "id_sel_a", 32'(id_sel_a), 32'd0);
        chk("R6", "id_cmp_a", id_cmp_a, id_reg_a);

        // R7: matching zero destinations never forward.
        set_case(5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0);
        chk("R7", "ex_sel_a", 32'(ex_sel_a), 32'd0);
        chk("R7", "ex_alu_b", ex_alu_b, ex_reg_b);
        chk("R7", "id_cmp_a", id_cmp_a, id_reg_a);

        // R8: both stages match; memory wins.
        set_case(5'd3, 5'd3, 5'd1, 5'd2, 5'd3, 1'b0, 5'd3);
        chk("R8", "ex_sel_a", 32'(ex_sel_a), 32'd1);
        chk("R8", "ex_alu_b", ex_alu_b, mem_value);

        // Random mix biased toward colliding register numbers and loads.
        for (int i = 0; i < N_RAND; i++) begin
            set_case(pick_reg(), pick_reg(), pick_reg(), pick_reg(), pick_reg(),
                     ($urandom_range(0, 2) == 0), pick_reg());
            check_all("RAND");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL WATCHDOG: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule